// File: doc/BRIEF.md
# ADC Conversion Control Core

This block is the register-mapped control core for an external sampling ADC. A host drives a simple word-addressed read/write port. Behind that port sit a version word, an instance identifier, a scratch word, an interface-type word, a control word, a conversion-rate word, a burst-length word, and a pair of data words that reach the converter's own registers over a parallel bus.

A programmable period timer drives the conversion-start output. It only runs while software has released the soft reset and set the enable bit. The converter's busy line is brought into the clock domain through a synchronizer. Each falling edge of busy produces a single-cycle end-of-conversion pulse, and downstream capture logic uses that pulse as its trigger.

Writes to the write-data word and reads of the read-data word produce single-cycle request strobes toward a separate parallel-bus strobe generator. Returned device data is held until the host reads it.

Top module: `adc_conv_ctrl_core`

## Requirements
- R1: After the synchronous reset, the outputs are as follows: conv_start_o, eoc_o, par_wr_req_o, par_rd_req_o and reg_rd_valid are 0. The control, rate, burst and scratch words read as 0.
- R2: A read is registered. reg_rd_valid and reg_rd_data appear in the cycle after the edge that samples reg_rd_en. Word 0x100 returns the VERSION parameter, word 0x101 returns the ID parameter, and word 0x103 returns the IF_TYPE parameter.
- R3: Word 0x102 is a 32-bit scratch register that reads back any value written to it.
- R4: Reads of unmapped word addresses return 0. Writes to words 0x100, 0x101, 0x103 and 0x113 change nothing.
- R5: Control word 0x110 has two fields: bit 0 is the active-low soft reset (reset value 0), and bit 1 is the pulse enable. The other bits read as 0. conv_start_o pulses only while both bits are 1.
- R6: Word 0x111 sets the pulse period P = max(rate,1) in clock cycles. With the core enabled at edge E0, conv_start_o is high for exactly one cycle after edges E0+P, E0+2P, and so on.
- R7: Clearing either control bit returns the period counter to 0. After re-enabling at edge E0, the next pulse follows edge E0+P.
- R8: Each falling edge of busy_i gives exactly one eoc_o cycle. That cycle follows the third rising clock edge after the fall when two synchronizer stages are used. Rising edges of busy_i give no pulse.
- R9: Word 0x112 holds a 5-bit burst length (length minus one), and bits above bit 4 read as 0. burst_len_o equals that value when IF_TYPE is nonzero and is 0 in serial builds.
- R10: A write to word 0x114 raises par_wr_req_o for the following cycle, with par_wr_data_o carrying the written value. Reads of 0x114 return 0.
- R11: Word 0x113 returns the last par_rd_data_i sampled with par_rd_valid_i high. A read of 0x113 raises par_rd_req_o in the cycle after the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Write word address |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | ADDR_W | Read word address |
| reg_rd_data | output | 32 | Read data, registered |
| reg_rd_valid | output | 1 | Read data valid |
| busy_i | input | 1 | Converter busy, asynchronous |
| conv_start_o | output | 1 | Conversion-start pulse |
| eoc_o | output | 1 | End-of-conversion pulse |
| burst_len_o | output | BURST_W | Burst length minus one (parallel builds) |
| par_wr_req_o | output | 1 | Device register write request |
| par_wr_data_o | output | 32 | Device register write data |
| par_rd_req_o | output | 1 | Device register read request |
| par_rd_data_i | input | 32 | Device register read data |
| par_rd_valid_i | input | 1 | Device read data valid |

## Verification
The bench builds the main instance with IF_TYPE=1 and a distinctive ID, so the parallel-only burst output can be seen. A second instance with IF_TYPE=0 sits on the same register bus, and it shows the serial build forcing the burst output to zero. The default two synchronizer stages fix the end-of-conversion latency at three edges, which the bench checks cycle by cycle. The bench sweeps rate values 0 to 6, covering the degenerate every-cycle case and several full periods of each. It also sweeps all 32 burst codes and a walking-ones scratch pattern.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int REG_W = 32;

  localparam logic [15:0] A_VERSION = 16'h0100;
  localparam logic [15:0] A_IDENT   = 16'h0101;
  localparam logic [15:0] A_SCRATCH = 16'h0102;
  localparam logic [15:0] A_IFTYPE  = 16'h0103;
  localparam logic [15:0] A_CTRL    = 16'h0110;
  localparam logic [15:0] A_RATE    = 16'h0111;
  localparam logic [15:0] A_BURST   = 16'h0112;
  localparam logic [15:0] A_RDATA   = 16'h0113;
  localparam logic [15:0] A_WDATA   = 16'h0114;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_VERSION, SEL_IDENT, SEL_SCRATCH, SEL_IFTYPE,
    SEL_CTRL, SEL_RATE, SEL_BURST, SEL_RDATA, SEL_WDATA
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic run_n;
  } ctrl_t;
endpackage

// File: rtl/conv_period_timer.sv
module conv_period_timer #(
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              pulse_o
);
  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] last;
  logic              active;
  logic              pulse_q;

  assign active = run_n & en;
  assign last   = (rate <= RATE_W'(1)) ? '0 : rate - RATE_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (cnt_q >= last) begin
      cnt_q   <= '0;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + RATE_W'(1);
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  // R5
  gated_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pulse_q);

  // R7
  counter_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> cnt_q == '0);
endmodule

// File: rtl/busy_fall_detect.sv
module busy_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  output logic eoc_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              eoc_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= busy_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      eoc_q  <= 1'b0;
    end else begin
      prev_q <= sync_q[STAGES-1];
      eoc_q  <= prev_q & ~sync_q[STAGES-1];
    end
  end

  assign eoc_o = eoc_q;

  // R8
  single_eoc_chk: assert property (@(posedge clk) disable iff (rst)
    eoc_q |=> !eoc_q);
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int          ADDR_W  = 10,
  parameter int          BURST_W = 5,
  parameter int          IF_TYPE = 1,
  parameter logic [31:0] ID      = 32'h0,
  parameter logic [31:0] VERSION = 32'h0002_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              rd_valid,
  output ctrl_t             ctrl,
  output logic [REG_W-1:0]  rate,
  output logic [BURST_W-1:0] burst,
  output logic              par_wr_req,
  output logic [REG_W-1:0]  par_wr_data,
  output logic              par_rd_req,
  input  logic [REG_W-1:0]  par_rd_data,
  input  logic              par_rd_valid
);
  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if      (a == ADDR_W'(A_VERSION)) s = SEL_VERSION;
    else if (a == ADDR_W'(A_IDENT))   s = SEL_IDENT;
    else if (a == ADDR_W'(A_SCRATCH)) s = SEL_SCRATCH;
    else if (a == ADDR_W'(A_IFTYPE))  s = SEL_IFTYPE;
    else if (a == ADDR_W'(A_CTRL))    s = SEL_CTRL;
    else if (a == ADDR_W'(A_RATE))    s = SEL_RATE;
    else if (a == ADDR_W'(A_BURST))   s = SEL_BURST;
    else if (a == ADDR_W'(A_RDATA))   s = SEL_RDATA;
    else if (a == ADDR_W'(A_WDATA))   s = SEL_WDATA;
    return s;
  endfunction

  reg_sel_e          wr_sel, rd_sel;
  logic [REG_W-1:0]  scratch_q, rate_q, cap_q, rmux;
  ctrl_t             ctrl_q;
  logic [BURST_W-1:0] burst_q;
  logic              wreq_q, rreq_q, rvalid_q;
  logic [REG_W-1:0]  wdata_q, rdata_q;

  assign wr_sel = wr_en ? decode(wr_addr) : SEL_NONE;
  assign rd_sel = decode(rd_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch_q <= '0;
      rate_q    <= '0;
      ctrl_q    <= '0;
      burst_q   <= '0;
      wreq_q    <= 1'b0;
      wdata_q   <= '0;
    end else begin
      wreq_q <= 1'b0;
      unique case (wr_sel)
        SEL_SCRATCH: scratch_q <= wr_data;
        SEL_CTRL:    ctrl_q    <= '{en: wr_data[1], run_n: wr_data[0]};
        SEL_RATE:    rate_q    <= wr_data;
        SEL_BURST:   burst_q   <= wr_data[BURST_W-1:0];
        SEL_WDATA: begin
          wreq_q  <= 1'b1;
          wdata_q <= wr_data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               cap_q <= '0;
    else if (par_rd_valid) cap_q <= par_rd_data;
  end

  always_comb begin
    rmux = '0;
    unique case (rd_sel)
      SEL_VERSION: rmux = VERSION;
      SEL_IDENT:   rmux = ID;
      SEL_SCRATCH: rmux = scratch_q;
      SEL_IFTYPE:  rmux = REG_W'(IF_TYPE);
      SEL_CTRL:    rmux = REG_W'(ctrl_q);
      SEL_RATE:    rmux = rate_q;
      SEL_BURST:   rmux = REG_W'(burst_q);
      SEL_RDATA:   rmux = cap_q;
      default:     rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      rreq_q   <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      rdata_q  <= rd_en ? rmux : '0;
      rreq_q   <= rd_en && (rd_sel == SEL_RDATA);
    end
  end

  assign rd_data     = rdata_q;
  assign rd_valid    = rvalid_q;
  assign ctrl        = ctrl_q;
  assign rate        = rate_q;
  assign burst       = burst_q;
  assign par_wr_req  = wreq_q;
  assign par_wr_data = wdata_q;
  assign par_rd_req  = rreq_q;

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid_q |-> $past(rd_en));

  // R10
  write_request_chk: assert property (@(posedge clk) disable iff (rst)
    wreq_q |-> $past(wr_en && decode(wr_addr) == SEL_WDATA));

  // R11
  read_request_chk: assert property (@(posedge clk) disable iff (rst)
    rreq_q |-> $past(rd_en && decode(rd_addr) == SEL_RDATA));
endmodule

// File: rtl/adc_conv_ctrl_core.sv
module adc_conv_ctrl_core
  import adc_ctrl_pkg::*;
#(
  parameter int          ADDR_W      = 10,
  parameter int          BURST_W     = 5,
  parameter int          SYNC_STAGES = 2,
  parameter int          IF_TYPE     = 1,
  parameter logic [31:0] ID          = 32'h0,
  parameter logic [31:0] VERSION     = 32'h0002_0100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_wr_addr,
  input  logic [31:0]        reg_wr_data,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_rd_addr,
  output logic [31:0]        reg_rd_data,
  output logic               reg_rd_valid,
  input  logic               busy_i,
  output logic               conv_start_o,
  output logic               eoc_o,
  output logic [BURST_W-1:0] burst_len_o,
  output logic               par_wr_req_o,
  output logic [31:0]        par_wr_data_o,
  output logic               par_rd_req_o,
  input  logic [31:0]        par_rd_data_i,
  input  logic               par_rd_valid_i
);
  ctrl_t              ctrl;
  logic [REG_W-1:0]   rate;
  logic [BURST_W-1:0] burst;

  adc_ctrl_regs #(
    .ADDR_W(ADDR_W), .BURST_W(BURST_W), .IF_TYPE(IF_TYPE),
    .ID(ID), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_en(reg_rd_en), .rd_addr(reg_rd_addr),
    .rd_data(reg_rd_data), .rd_valid(reg_rd_valid),
    .ctrl(ctrl), .rate(rate), .burst(burst),
    .par_wr_req(par_wr_req_o), .par_wr_data(par_wr_data_o),
    .par_rd_req(par_rd_req_o),
    .par_rd_data(par_rd_data_i), .par_rd_valid(par_rd_valid_i)
  );

  conv_period_timer #(.RATE_W(REG_W)) u_timer (
    .clk(clk), .rst(rst), .run_n(ctrl.run_n), .en(ctrl.en),
    .rate(rate), .pulse_o(conv_start_o)
  );

  busy_fall_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .busy_i(busy_i), .eoc_o(eoc_o)
  );

  if (IF_TYPE != 0) begin : g_par
    assign burst_len_o = burst;
  end else begin : g_ser
    assign burst_len_o = '0;
  end
endmodule

// File: tb/adc_conv_ctrl_core_test.sv
module adc_conv_ctrl_core_test;
  localparam int AW = 10;
  localparam logic [31:0] VER = 32'h0002_0100;
  localparam logic [31:0] IDV = 32'h0000_005A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, busy = 1'b0, prv = 1'b0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [31:0] wd = '0, prd = '0;
  logic [31:0] rdata, rdata_s, pwd, pwd_s;
  logic rvalid, rvalid_s, conv, conv_s, eoc, eoc_s;
  logic pwr, pwr_s, prr, prr_s;
  logic [4:0] bl, bl_s;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_conv_ctrl_core #(.ADDR_W(AW), .IF_TYPE(1), .ID(IDV), .VERSION(VER)) uut (
    .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_addr(wa), .reg_wr_data(wd),
    .reg_rd_en(rd_en), .reg_rd_addr(ra), .reg_rd_data(rdata), .reg_rd_valid(rvalid),
    .busy_i(busy), .conv_start_o(conv), .eoc_o(eoc), .burst_len_o(bl),
    .par_wr_req_o(pwr), .par_wr_data_o(pwd), .par_rd_req_o(prr),
    .par_rd_data_i(prd), .par_rd_valid_i(prv));

  adc_conv_ctrl_core #(.ADDR_W(AW), .IF_TYPE(0), .ID(IDV), .VERSION(VER)) uut_ser (
    .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_addr(wa), .reg_wr_data(wd),
    .reg_rd_en(rd_en), .reg_rd_addr(ra), .reg_rd_data(rdata_s), .reg_rd_valid(rvalid_s),
    .busy_i(busy), .conv_start_o(conv_s), .eoc_o(eoc_s), .burst_len_o(bl_s),
    .par_wr_req_o(pwr_s), .par_wr_data_o(pwd_s), .par_rd_req_o(prr_s),
    .par_rd_data_i(prd), .par_rd_valid_i(prv));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wa = a; wd = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; ra = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    check("R2 valid", 32'(rvalid), 32'd1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 conv", 32'(conv), 0);
    check("R1 eoc", 32'(eoc), 0);
    check("R1 wreq", 32'(pwr), 0);
    check("R1 rreq", 32'(prr), 0);
    check("R1 rvalid", 32'(rvalid), 0);
    rd(10'h110, v); check("R1 ctrl", v, 0);
    rd(10'h111, v); check("R1 rate", v, 0);
    rd(10'h112, v); check("R1 burst", v, 0);
    rd(10'h102, v); check("R1 scratch", v, 0);

    // R2 constant words
    rd(10'h100, v); check("R2 version", v, VER);
    rd(10'h101, v); check("R2 id", v, IDV);
    rd(10'h103, v); check("R2 iftype", v, 32'd1);
    check("R2 iftype serial", rdata_s, 32'd0);

    // R3 scratch walking ones and patterns
    for (int i = 0; i < 32; i++) begin
      wr(10'h102, 32'd1 << i); rd(10'h102, v); check("R3 scratch", v, 32'd1 << i);
    end
    wr(10'h102, 32'hA5C3_0FF0); rd(10'h102, v); check("R3 scratch", v, 32'hA5C3_0FF0);

    // R11 capture device read data
    @(negedge clk); prd = 32'h1234_5678; prv = 1'b1;
    @(negedge clk); prv = 1'b0; prd = 32'hFFFF_FFFF;
    rd(10'h113, v); check("R11 rdata", v, 32'h1234_5678);
    check("R11 rreq", 32'(prr), 1);
    @(negedge clk); check("R11 rreq drop", 32'(prr), 0);

    // R4 unmapped reads and read-only writes
    rd(10'h000, v); check("R4 unmapped", v, 0);
    rd(10'h104, v); check("R4 unmapped", v, 0);
    rd(10'h10F, v); check("R4 unmapped", v, 0);
    rd(10'h115, v); check("R4 unmapped", v, 0);
    rd(10'h3FF, v); check("R4 unmapped", v, 0);
    wr(10'h100, 32'hDEAD_BEEF); rd(10'h100, v); check("R4 ro version", v, VER);
    wr(10'h101, 32'hDEAD_BEEF); rd(10'h101, v); check("R4 ro id", v, IDV);
    wr(10'h103, 32'hDEAD_BEEF); rd(10'h103, v); check("R4 ro iftype", v, 1);
    wr(10'h113, 32'hDEAD_BEEF); rd(10'h113, v); check("R4 ro rdata", v, 32'h1234_5678);

    // R10 device write request
    wr(10'h114, 32'hCAFE_0042);
    check("R10 wreq", 32'(pwr), 1);
    check("R10 wdata", pwd, 32'hCAFE_0042);
    @(negedge clk); check("R10 wreq drop", 32'(pwr), 0);
    rd(10'h114, v); check("R10 wo read", v, 0);

    // R5 control fields and gating
    wr(10'h110, 32'hFFFF_FFFF); rd(10'h110, v); check("R5 ctrl mask", v, 3);
    wr(10'h111, 32'd2);
    wr(10'h110, 32'd1);
    for (int k = 0; k < 20; k++) begin @(negedge clk); check("R5 en off", 32'(conv), 0); end
    wr(10'h110, 32'd2);
    for (int k = 0; k < 20; k++) begin @(negedge clk); check("R5 in reset", 32'(conv), 0); end
    wr(10'h110, 32'd0);

    // R6 rate sweep
    for (int r = 0; r <= 6; r++) begin
      int p;
      p = (r == 0) ? 1 : r;
      wr(10'h111, 32'(r));
      wr(10'h110, 32'd3);
      for (int k = 0; k <= 3 * p; k++) begin
        check("R6 period", 32'(conv), 32'((k > 0) && (k % p == 0)));
        @(negedge clk);
      end
      wr(10'h110, 32'd0);
    end

    // R7 restart after clearing enable, then after clearing reset bit
    wr(10'h111, 32'd5);
    wr(10'h110, 32'd3);
    repeat (3) @(negedge clk);
    wr(10'h110, 32'd1);
    wr(10'h110, 32'd3);
    for (int k = 0; k <= 10; k++) begin
      check("R7 restart en", 32'(conv), 32'((k > 0) && (k % 5 == 0)));
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    wr(10'h110, 32'd2);
    wr(10'h110, 32'd3);
    for (int k = 0; k <= 5; k++) begin
      check("R7 restart rst", 32'(conv), 32'(k == 5));
      @(negedge clk);
    end
    wr(10'h110, 32'd0);

    // R8 busy edges
    for (int h = 1; h <= 5; h++) begin
      @(negedge clk); busy = 1'b1;
      for (int k = 0; k < h + 4; k++) begin @(negedge clk); check("R8 rise", 32'(eoc), 0); end
      busy = 1'b0;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        check("R8 fall", 32'(eoc), 32'(k == 3));
      end
    end

    // R9 burst sweep
    for (int b = 0; b < 32; b++) begin
      wr(10'h112, 32'hFFFF_FFE0 | 32'(b));
      rd(10'h112, v);
      check("R9 burst read", v, 32'(b));
      check("R9 burst out", 32'(bl), 32'(b));
      check("R9 burst serial", 32'(bl_s), 0);
    end

    finish_run();
  end
endmodule